// File: doc/BRIEF.md
# Nested Priority Interrupt Controller with Per-Level Acknowledge Chains

The controller collects interrupt requests from devices grouped into a fixed number of priority levels, where level 0 is the most urgent. A request is held as pending until it is serviced. The controller raises its interrupt line to the processor whenever some pending level is more urgent than the level whose handler is running now. When the processor answers with a one-cycle acknowledge pulse, the acknowledge goes to the most urgent pending level. Within that level it travels along a chain of devices, ordered from nearest to farthest. The first device on the chain that has a request keeps the acknowledge, and its identifier appears on the vector output in the same cycle.

Handlers turn interrupts back on while they run, so a more urgent request can preempt a handler that has not finished. The controller records the levels in service on a small stack. Each acknowledge pushes the granted level. Each end-of-handler strobe pops one entry, so handlers complete in the reverse order of their nesting.

Top module: `pic_daisy_top`

## Requirements
- R1: After reset, `irq_o` is 0, `ack_o` is all zero, `vec_vld_o` is 0, and `cur_lvl_o` equals NUM_LVL, the idle code meaning no handler is in service.
- R2: A 1 on bit i of `req_i` in any cycle makes device i pending from the next cycle on. The device stays pending until it is acknowledged, even if many cycles pass with no acknowledge. Device i belongs to level i / DEVS, at chain position i % DEVS, and position 0 is nearest the processor.
- R3: `irq_o` is 1 exactly when some device is pending and the most urgent pending level is numerically smaller than `cur_lvl_o`.
- R4: An `inta_i` pulse while `irq_o` is 1 grants exactly one device, and that device belongs to the most urgent pending level.
- R5: Within the granted level, the pending device at the lowest chain position takes the grant. Pending devices further down the chain see no acknowledge.
- R6: In the grant cycle, `vec_vld_o` is 1 and `vec_o` equals the flat device index (level*DEVS + position). In every other cycle `vec_vld_o` is 0.
- R7: A granted device is no longer pending from the next cycle on, unless `req_i` asserts it again in that same cycle.
- R8: A grant pushes the granted level, so the next cycle shows it on `cur_lvl_o`.
- R9: `eoi_i` pops one level, and `cur_lvl_o` returns to the level that was in service before. `eoi_i` has no effect when nothing is in service.
- R10: An `inta_i` pulse while `irq_o` is 0 grants nothing and leaves the pending and in-service state unchanged.
- R11: When `inta_i` grants in the same cycle as `eoi_i`, the pop happens first and then the push. The granted level replaces the top of the stack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_LVL*DEVS | Request strobes, one bit per device, grouped by level |
| inta_i | input | 1 | Acknowledge pulse from the processor |
| eoi_i | input | 1 | End-of-handler strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_o | output | NUM_LVL*DEVS | One-hot acknowledge to the granted device |
| vec_vld_o | output | 1 | Vector valid during the grant cycle |
| vec_o | output | clog2(NUM_LVL*DEVS) | Identifier of the granted device |
| cur_lvl_o | output | clog2(NUM_LVL+1) | Level in service, or NUM_LVL when idle |

## Verification
The bench builds the block with its defaults: three levels of four devices each. With these values the stack can fill to its full depth of three nested handlers, and each chain is long enough that a grant has to skip pending devices further down. Random request strobes, acknowledges and end-of-handler strobes run against a reference model in the bench. Directed sequences cover several requests on one chain at once, an acknowledge while `irq_o` is low, an end-of-handler strobe on an empty stack, and an acknowledge and an end-of-handler strobe in the same cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned DEF_LVLS = 3;
  localparam int unsigned DEF_DEVS = 4;
endpackage

// File: rtl/pic_pend_bank.sv
module pic_pend_bank #(
  parameter int unsigned N = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  // set wins over clear so a fresh request is never lost
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (pend_o & ~clr_i) | set_i;
endmodule

// File: rtl/pic_daisy_chain.sv
module pic_daisy_chain #(
  parameter int unsigned NUM_LVL = 3,
  parameter int unsigned DEVS    = 4
) (
  input  logic [NUM_LVL*DEVS-1:0] pend_i,
  input  logic [NUM_LVL-1:0]      lvl_sel_i,
  output logic [NUM_LVL*DEVS-1:0] grant_o
);
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [DEVS-1:0] p;
    logic [DEVS-1:0] first;
    assign p = pend_i[l*DEVS +: DEVS];
    // lowest set bit: acknowledge passes idle devices, stops at first requester
    assign first = p & (~p + DEVS'(1));
    assign grant_o[l*DEVS +: DEVS] = lvl_sel_i[l] ? first : '0;
  end
endmodule

// File: rtl/pic_lvl_stack.sv
module pic_lvl_stack #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned W     = 2,
  parameter int unsigned IDLE  = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_val_i,
  output logic [W-1:0] top_o
);
  localparam int unsigned SP_W = $clog2(DEPTH + 1);

  logic [W-1:0]    mem_q [DEPTH];
  logic [SP_W-1:0] sp_q;
  logic            pop_eff;
  logic [SP_W-1:0] wr_idx;

  assign pop_eff = pop_i && (sp_q != '0);
  assign wr_idx  = sp_q - SP_W'(pop_eff);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) mem_q[wr_idx] <= push_val_i;
      sp_q <= wr_idx + SP_W'(push_i);
    end

  assign top_o = (sp_q == '0) ? W'(IDLE) : mem_q[sp_q - SP_W'(1)];
endmodule

// File: rtl/pic_daisy_top.sv
module pic_daisy_top #(
  parameter int unsigned NUM_LVL = pic_pkg::DEF_LVLS,
  parameter int unsigned DEVS    = pic_pkg::DEF_DEVS
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_LVL*DEVS-1:0]             req_i,
  input  logic                                inta_i,
  input  logic                                eoi_i,
  output logic                                irq_o,
  output logic [NUM_LVL*DEVS-1:0]             ack_o,
  output logic                                vec_vld_o,
  output logic [$clog2(NUM_LVL*DEVS)-1:0]     vec_o,
  output logic [$clog2(NUM_LVL+1)-1:0]        cur_lvl_o
);
  localparam int unsigned N     = NUM_LVL * DEVS;
  localparam int unsigned LVL_W = $clog2(NUM_LVL + 1);
  localparam int unsigned VEC_W = $clog2(N);

  logic [N-1:0]       pend;
  logic [NUM_LVL-1:0] lvl_pend;
  logic [NUM_LVL-1:0] lvl_sel;
  logic [LVL_W-1:0]   best;
  logic [LVL_W-1:0]   cur;
  logic               take;

  pic_pend_bank #(.N(N)) i_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(req_i), .clr_i(ack_o), .pend_o(pend)
  );

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lp
    assign lvl_pend[l] = |pend[l*DEVS +: DEVS];
  end

  always_comb begin
    best = LVL_W'(NUM_LVL);
    for (int l = NUM_LVL - 1; l >= 0; l--)
      if (lvl_pend[l]) best = LVL_W'(l);
  end

  assign irq_o   = (|lvl_pend) && (best < cur);
  assign take    = inta_i && irq_o;
  assign lvl_sel = take ? (NUM_LVL'(1) << best) : '0;

  pic_daisy_chain #(.NUM_LVL(NUM_LVL), .DEVS(DEVS)) i_chain (
    .pend_i(pend), .lvl_sel_i(lvl_sel), .grant_o(ack_o)
  );

  always_comb begin
    vec_o = '0;
    for (int i = 0; i < N; i++)
      if (ack_o[i]) vec_o = VEC_W'(i);
  end
  assign vec_vld_o = |ack_o;

  pic_lvl_stack #(.DEPTH(NUM_LVL), .W(LVL_W), .IDLE(NUM_LVL)) i_stack (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(take), .pop_i(eoi_i),
    .push_val_i(best), .top_o(cur)
  );

  assign cur_lvl_o = cur;
endmodule

// File: rtl/pic_daisy_chk.sv
module pic_daisy_chk #(
  parameter int unsigned NUM_LVL = 3,
  parameter int unsigned DEVS    = 4
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            inta_i,
  input logic                            eoi_i,
  input logic                            irq_o,
  input logic [NUM_LVL*DEVS-1:0]         ack_o,
  input logic                            vec_vld_o,
  input logic [$clog2(NUM_LVL*DEVS)-1:0] vec_o,
  input logic [$clog2(NUM_LVL+1)-1:0]    cur_lvl_o
);
  a_r5_grant_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o));

  a_r10_ack_needs_inta: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_o) |-> (inta_i && irq_o));

  a_r4_inta_grants: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && irq_o) |-> vec_vld_o);

  a_r4_grant_outranks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |-> (int'(vec_o) / DEVS) < int'(cur_lvl_o));

  a_r3_irq_not_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cur_lvl_o != '0);

  a_r8_push_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |=> int'(cur_lvl_o) == int'($past(vec_o)) / DEVS);
endmodule

bind pic_daisy_top pic_daisy_chk #(.NUM_LVL(NUM_LVL), .DEVS(DEVS)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .inta_i(inta_i), .eoi_i(eoi_i),
  .irq_o(irq_o), .ack_o(ack_o), .vec_vld_o(vec_vld_o), .vec_o(vec_o),
  .cur_lvl_o(cur_lvl_o)
);

// File: tb/test_pic_daisy_top.sv
module test_pic_daisy_top;
  localparam int CLK_P = 10;
  localparam int NL = 3;
  localparam int ND = 4;
  localparam int N  = NL * ND;

  logic          clk_i = 0;
  logic          rst_ni = 0;
  logic [N-1:0]  req_i = '0;
  logic          inta_i = 0;
  logic          eoi_i = 0;
  logic          irq_o;
  logic [N-1:0]  ack_o;
  logic          vec_vld_o;
  logic [3:0]    vec_o;
  logic [1:0]    cur_lvl_o;

  int checks = 0;
  int errors = 0;

  logic [N-1:0] pend_m = '0;
  int stk[NL];
  int sp = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  pic_daisy_top #(.NUM_LVL(NL), .DEVS(ND)) i_pic_daisy_top (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int cur_m();
    return (sp == 0) ? NL : stk[sp-1];
  endfunction

  function automatic int best_m();
    for (int l = 0; l < NL; l++)
      if (|pend_m[l*ND +: ND]) return l;
    return NL;
  endfunction

  // one cycle: drive at negedge, compare combinational outputs, advance model
  task automatic step(input logic [N-1:0] req, input bit inta, input bit eoi, input string tag);
    int b, g;
    bit e_irq;
    req_i = req; inta_i = inta; eoi_i = eoi;
    #1;
    b = best_m();
    e_irq = (b < NL) && (b < cur_m());
    g = -1;
    if (inta && e_irq)
      for (int k = ND - 1; k >= 0; k--)
        if (pend_m[b*ND + k]) g = b*ND + k;
    chk(tag, "irq", int'(irq_o), int'(e_irq));
    chk(tag, "cur_lvl", int'(cur_lvl_o), cur_m());
    chk(tag, "vec_vld", int'(vec_vld_o), int'(g >= 0));
    chk(tag, "ack", int'(ack_o), (g >= 0) ? (1 << g) : 0);
    if (g >= 0) chk(tag, "vec", int'(vec_o), g);
    if (g >= 0) pend_m[g] = 1'b0;
    pend_m = pend_m | req;
    if (eoi && sp > 0) sp--;
    if (g >= 0) begin stk[sp] = b; sp++; end
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    // R1 reset state
    chk("R1", "irq", int'(irq_o), 0);
    chk("R1", "ack", int'(ack_o), 0);
    chk("R1", "vec_vld", int'(vec_vld_o), 0);
    chk("R1", "cur_lvl", int'(cur_lvl_o), NL);
    @(negedge clk_i);

    step('0, 1, 0, "R10");             // acknowledge with nothing pending
    step('0, 0, 1, "R9");              // end-of-handler on empty stack
    step(N'(1) << 9, 0, 0, "R2");      // level 2, position 1
    repeat (4) step('0, 0, 0, "R2");   // stays pending, irq held (R3)
    step(N'(3) << 5, 0, 0, "R3");      // level 1 positions 1 and 2
    step('0, 1, 0, "R4");              // level 1 beats level 2, position 1 first (R5, R6)
    step('0, 0, 0, "R8");              // now serving level 1
    step('0, 1, 0, "R10");             // level 1 pending, not strictly higher
    step(N'(1) << 3, 0, 0, "R3");      // level 0 position 3
    step('0, 1, 0, "R5");              // nest level 0
    step('0, 1, 0, "R7");              // granted device gone, nothing outranks level 0
    step('0, 0, 1, "R9");              // back to level 1
    step('0, 0, 1, "R9");              // idle again
    step('0, 1, 1, "R11");             // grant level 1 position 2 with pop on empty
    step(N'(1) << 0, 0, 0, "R11");
    step('0, 1, 1, "R11");             // pop level 1, push level 0
    step('0, 0, 1, "R9");
    step('0, 1, 0, "R4");              // remaining level 2 device
    step('0, 0, 1, "R9");

    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] r;
      r = '0;
      for (int k = 0; k < N; k++) r[k] = ($urandom % 16) == 0;
      step(r, ($urandom % 3) == 0, ($urandom % 4) == 0, "RND");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule